// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block owns the status word of a simple processor core and the save/restore register pairs used when the core takes or leaves an exception. When the core raises an exception it supplies a cause code and its program counter. In the next clock the block does four things. It records a resume address and a filtered copy of the status word in the pair that belongs to the cause. It replaces the status word with the handler's initial value. It looks up the handler address in a writable per-cause vector table and combines it with a base prefix. It then emits a one-cycle redirect pulse that carries that address.

On a return request the block reads the pair selected by the return kind. It restores the status word under a mask that depends on that kind, and it redirects to the saved address with its two low bits cleared. Three further conditions are reported on outputs. A machine check that arrives while machine checks are disabled stops the block for good. A cause whose vector entry was never written is flagged as an error. When the saved status shows that instruction or data relocation was on, a flush indication is raised.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the status word and all four save pairs read zero, no redirect, flush, error or checkstop is raised, and every vector entry holds all ones (undefined) until it is written.
- R2: On an accepted exception the saved status equals the current status with the bits of mask 0x783F0000 cleared.
- R3: After an accepted exception the status word keeps only the machine-check-enable bit (bit 12) of the old status and clears every other bit. For cause 1 (machine check) bit 12 is cleared as well, so the status becomes zero.
- R4: Causes 4 to 7 (faults) save PC minus 4 as the resume address. All other causes save PC.
- R5: An accepted exception produces, one clock after the request, a single-cycle redirect pulse whose address is the vector entry of the cause ORed with the base prefix. No redirect appears without a request in the previous cycle.
- R6: If the vector entry of the cause is all ones, the block raises a one-cycle vector-error pulse instead of a redirect, and the status word and the save pairs are left unchanged.
- R7: Pair index 3 receives cause 1 (machine check), pair 1 receives cause 2 (critical), pair 2 receives cause 3 (debug), and pair 0 receives every other cause. Saves for causes 1 and 3 are also copied into pair 1.
- R8: A machine check (cause 1) taken while status bit 12 is 0 sets a sticky checkstop output. From then on every exception, return and status load is ignored until reset.
- R9: A return of kind k (0 normal, 1 critical, 2 debug, 3 machine check) redirects one clock later to saved PC k with bits 1:0 cleared. It loads the status word with saved status k ANDed with the inverse of 0x783F0000 for kind 0, or with the inverse of 0x3FFF0000 for the other kinds.
- R10: The flush output pulses together with an exception redirect exactly when bit 5 (instruction relocation) or bit 4 (data relocation) of the saved status is set. It stays low on returns.
- R11: In one cycle an exception request takes precedence over a return request, and both take precedence over a status load. A status load that is not overridden writes the status word one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vec_we_i | input | 1 | Vector table write strobe |
| vec_idx_i | input | CW | Vector table entry to write |
| vec_data_i | input | XLEN | Vector table write data |
| vec_base_i | input | XLEN | Base prefix ORed into every handler address |
| st_load_i | input | 1 | Direct status word write |
| st_load_val_i | input | XLEN | Value for a direct status write |
| exc_req_i | input | 1 | Exception request |
| exc_cause_i | input | CW | Exception cause code |
| exc_pc_i | input | XLEN | Program counter at the exception |
| ret_req_i | input | 1 | Return request |
| ret_kind_i | input | 2 | Return kind selecting the save pair |
| status_o | output | XLEN | Current status word |
| redir_o | output | 1 | One-cycle redirect pulse |
| redir_addr_o | output | XLEN | Redirect target address |
| flush_o | output | 1 | Translation flush indication |
| vec_err_o | output | 1 | Undefined vector pulse |
| chkstop_o | output | 1 | Sticky checkstop |
| save_pc_o | output | 4*XLEN | Saved PCs, pair k at bits k*XLEN upward |
| save_st_o | output | 4*XLEN | Saved status words, pair k at bits k*XLEN upward |

## Verification
The status word and all save pairs are on the ports. A wrong filter, a wrong pair selection or a missed alternate copy therefore shows in the first cycle after the offending request. A corrupted vector entry is visible only when its cause is raised, as a wrong redirect address or a spurious error pulse in that same cycle. A false checkstop silences every later redirect. A wrong return mask first appears in the status word one clock after the return.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
package tseq_pkg;

   typedef enum logic [1:0] {
      PAIR_STD  = 2'd0,
      PAIR_CRIT = 2'd1,
      PAIR_DBG  = 2'd2,
      PAIR_MCHK = 2'd3
   } pair_e;

   localparam int NPAIR = 4;

   localparam logic [7:0] CAUSE_MCHK     = 8'd1;
   localparam logic [7:0] CAUSE_CRIT     = 8'd2;
   localparam logic [7:0] CAUSE_DBG      = 8'd3;
   localparam logic [7:0] CAUSE_FAULT_LO = 8'd4;
   localparam logic [7:0] CAUSE_FAULT_HI = 8'd7;

   // save pair that a cause lands in
   function automatic pair_e pair_of(input logic [7:0] c);
      case (c)
         CAUSE_MCHK: return PAIR_MCHK;
         CAUSE_CRIT: return PAIR_CRIT;
         CAUSE_DBG:  return PAIR_DBG;
         default:    return PAIR_STD;
      endcase
   endfunction

   // faults resume at the faulting instruction
   function automatic logic saves_current(input logic [7:0] c);
      return (c >= CAUSE_FAULT_LO) && (c <= CAUSE_FAULT_HI);
   endfunction

   // causes whose save is mirrored into the critical pair
   function automatic logic has_alt(input logic [7:0] c);
      return (c == CAUSE_MCHK) || (c == CAUSE_DBG);
   endfunction

endpackage

// File: rtl/tseq_vectab.sv
`timescale 1ns/1ps
module tseq_vectab #(
   parameter int XLEN   = 32,
   parameter int NCAUSE = 16,
   localparam int CW    = $clog2(NCAUSE)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            we_i,
   input  logic [CW-1:0]   widx_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic [CW-1:0]   ridx_i,
   output logic [XLEN-1:0] rdata_o
);

   if ((1 << CW) != NCAUSE) begin : g_bad_depth
      $error("tseq_vectab: NCAUSE must be a power of two");
   end

   logic [XLEN-1:0] tab_q [NCAUSE];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < NCAUSE; i++) tab_q[i] <= '1;
      end else if (we_i) begin
         tab_q[widx_i] <= wdata_i;
      end
   end

   assign rdata_o = tab_q[ridx_i];

   // R1: a written entry holds the written word
   a_r1_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> tab_q[$past(widx_i)] == $past(wdata_i));

endmodule

// File: rtl/tseq_entry.sv
`timescale 1ns/1ps
module tseq_entry
   import tseq_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int CW   = 4,
   parameter int ME_BIT = 12,
   parameter int IR_BIT = 5,
   parameter int DR_BIT = 4,
   parameter logic [XLEN-1:0] SAVE_CLR = 32'h783F0000
) (
   input  logic [XLEN-1:0] cur_st_i,
   input  logic [CW-1:0]   cause_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] vec_i,
   input  logic [XLEN-1:0] base_i,
   output logic [XLEN-1:0] sv_st_o,
   output logic [XLEN-1:0] sv_pc_o,
   output logic [XLEN-1:0] new_st_o,
   output logic [XLEN-1:0] hnd_o,
   output pair_e           pair_o,
   output pair_e           alt_pair_o,
   output logic            alt_o,
   output logic            mchk_o,
   output logic            undef_o,
   output logic            flush_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [7:0] c8;
   assign c8 = 8'(cause_i);

   always_comb begin
      sv_st_o          = cur_st_i & ~SAVE_CLR;
      pair_o           = pair_of(c8);
      alt_o            = has_alt(c8);
      alt_pair_o       = PAIR_CRIT;
      mchk_o           = (pair_o == PAIR_MCHK);
      new_st_o         = '0;
      new_st_o[ME_BIT] = cur_st_i[ME_BIT] & ~mchk_o;
      sv_pc_o          = saves_current(c8) ? (pc_i - STEP) : pc_i;
      undef_o          = &vec_i;
      hnd_o            = vec_i | base_i;
      flush_o          = sv_st_o[IR_BIT] | sv_st_o[DR_BIT];
   end

endmodule

// File: rtl/tseq_savebank.sv
`timescale 1ns/1ps
module tseq_savebank
   import tseq_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter bit ALT_COPY = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  we_i,
   input  pair_e                 pair_i,
   input  logic                  alt_i,
   input  pair_e                 alt_pair_i,
   input  logic [XLEN-1:0]       pc_i,
   input  logic [XLEN-1:0]       st_i,
   input  pair_e                 rd_pair_i,
   output logic [XLEN-1:0]       rd_pc_o,
   output logic [XLEN-1:0]       rd_st_o,
   output logic [NPAIR*XLEN-1:0] flat_pc_o,
   output logic [NPAIR*XLEN-1:0] flat_st_o
);

   logic alt_en;

   if (ALT_COPY) begin : g_alt
      assign alt_en = we_i & alt_i;
   end else begin : g_noalt
      assign alt_en = 1'b0;
   end

   for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      logic [XLEN-1:0] pc_r;
      logic [XLEN-1:0] st_r;
      logic            hit;

      assign hit = (we_i && (pair_i == pair_e'(g))) ||
                   (alt_en && (alt_pair_i == pair_e'(g)));

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            pc_r <= '0;
            st_r <= '0;
         end else if (hit) begin
            pc_r <= pc_i;
            st_r <= st_i;
         end
      end

      assign flat_pc_o[g*XLEN +: XLEN] = pc_r;
      assign flat_st_o[g*XLEN +: XLEN] = st_r;
   end

   assign rd_pc_o = flat_pc_o[int'(rd_pair_i)*XLEN +: XLEN];
   assign rd_st_o = flat_st_o[int'(rd_pair_i)*XLEN +: XLEN];

endmodule

// File: rtl/tseq_return.sv
`timescale 1ns/1ps
module tseq_return
   import tseq_pkg::*;
#(
   parameter int XLEN = 32,
   parameter logic [XLEN-1:0] STD_CLR = 32'h783F0000,
   parameter logic [XLEN-1:0] ALT_CLR = 32'h3FFF0000
) (
   input  pair_e           kind_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] st_i,
   output logic [XLEN-1:0] tgt_o,
   output logic [XLEN-1:0] st_o
);

   logic [XLEN-1:0] clr;

   always_comb begin
      clr   = (kind_i == PAIR_STD) ? STD_CLR : ALT_CLR;
      st_o  = st_i & ~clr;
      tgt_o = {pc_i[XLEN-1:2], 2'b00};
   end

endmodule

// File: rtl/trap_sequencer.sv
`timescale 1ns/1ps
module trap_sequencer
   import tseq_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NCAUSE   = 16,
   parameter int ME_BIT   = 12,
   parameter int IR_BIT   = 5,
   parameter int DR_BIT   = 4,
   parameter bit ALT_COPY = 1'b1,
   parameter logic [XLEN-1:0] SAVE_CLR    = 32'h783F0000,
   parameter logic [XLEN-1:0] STD_RET_CLR = 32'h783F0000,
   parameter logic [XLEN-1:0] ALT_RET_CLR = 32'h3FFF0000,
   localparam int CW = $clog2(NCAUSE)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  vec_we_i,
   input  logic [CW-1:0]         vec_idx_i,
   input  logic [XLEN-1:0]       vec_data_i,
   input  logic [XLEN-1:0]       vec_base_i,
   input  logic                  st_load_i,
   input  logic [XLEN-1:0]       st_load_val_i,
   input  logic                  exc_req_i,
   input  logic [CW-1:0]         exc_cause_i,
   input  logic [XLEN-1:0]       exc_pc_i,
   input  logic                  ret_req_i,
   input  logic [1:0]            ret_kind_i,
   output logic [XLEN-1:0]       status_o,
   output logic                  redir_o,
   output logic [XLEN-1:0]       redir_addr_o,
   output logic                  flush_o,
   output logic                  vec_err_o,
   output logic                  chkstop_o,
   output logic [NPAIR*XLEN-1:0] save_pc_o,
   output logic [NPAIR*XLEN-1:0] save_st_o
);

   if (NCAUSE < 8 || CW > 8) begin : g_bad_ncause
      $error("trap_sequencer: NCAUSE must lie between 8 and 256");
   end
   if (ME_BIT >= XLEN || IR_BIT >= XLEN || DR_BIT >= XLEN || XLEN < 8) begin : g_bad_bits
      $error("trap_sequencer: status bit positions exceed XLEN");
   end

   logic [XLEN-1:0] status_q, redir_addr_q;
   logic            redir_q, flush_q, verr_q, chk_q;

   logic [XLEN-1:0] vec_rd, sv_st, sv_pc, new_st, hnd;
   pair_e           pair, alt_pair;
   logic            alt, is_mchk, undef, flush_need;
   logic [XLEN-1:0] rd_pc, rd_st, ret_tgt, ret_st;
   logic            act_exc, mchk_stop, take_exc, vec_bad, take_ret, do_ld;

   tseq_vectab #(.XLEN(XLEN), .NCAUSE(NCAUSE)) i_vectab (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (vec_we_i),
      .widx_i  (vec_idx_i),
      .wdata_i (vec_data_i),
      .ridx_i  (exc_cause_i),
      .rdata_o (vec_rd)
   );

   tseq_entry #(
      .XLEN(XLEN), .CW(CW), .ME_BIT(ME_BIT), .IR_BIT(IR_BIT),
      .DR_BIT(DR_BIT), .SAVE_CLR(SAVE_CLR)
   ) i_entry (
      .cur_st_i   (status_q),
      .cause_i    (exc_cause_i),
      .pc_i       (exc_pc_i),
      .vec_i      (vec_rd),
      .base_i     (vec_base_i),
      .sv_st_o    (sv_st),
      .sv_pc_o    (sv_pc),
      .new_st_o   (new_st),
      .hnd_o      (hnd),
      .pair_o     (pair),
      .alt_pair_o (alt_pair),
      .alt_o      (alt),
      .mchk_o     (is_mchk),
      .undef_o    (undef),
      .flush_o    (flush_need)
   );

   // request arbitration: checkstop freezes all, exception > return > load
   always_comb begin
      act_exc   = exc_req_i && !chk_q;
      mchk_stop = act_exc && is_mchk && !status_q[ME_BIT];
      take_exc  = act_exc && !mchk_stop && !undef;
      vec_bad   = act_exc && !mchk_stop && undef;
      take_ret  = !chk_q && !exc_req_i && ret_req_i;
      do_ld     = !chk_q && !exc_req_i && !ret_req_i && st_load_i;
   end

   tseq_savebank #(.XLEN(XLEN), .ALT_COPY(ALT_COPY)) i_savebank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (take_exc),
      .pair_i     (pair),
      .alt_i      (alt),
      .alt_pair_i (alt_pair),
      .pc_i       (sv_pc),
      .st_i       (sv_st),
      .rd_pair_i  (pair_e'(ret_kind_i)),
      .rd_pc_o    (rd_pc),
      .rd_st_o    (rd_st),
      .flat_pc_o  (save_pc_o),
      .flat_st_o  (save_st_o)
   );

   tseq_return #(
      .XLEN(XLEN), .STD_CLR(STD_RET_CLR), .ALT_CLR(ALT_RET_CLR)
   ) i_return (
      .kind_i (pair_e'(ret_kind_i)),
      .pc_i   (rd_pc),
      .st_i   (rd_st),
      .tgt_o  (ret_tgt),
      .st_o   (ret_st)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         status_q     <= '0;
         redir_q      <= 1'b0;
         redir_addr_q <= '0;
         flush_q      <= 1'b0;
         verr_q       <= 1'b0;
         chk_q        <= 1'b0;
      end else begin
         redir_q <= take_exc | take_ret;
         flush_q <= take_exc & flush_need;
         verr_q  <= vec_bad;
         chk_q   <= chk_q | mchk_stop;
         if (take_exc) begin
            status_q     <= new_st;
            redir_addr_q <= hnd;
         end else if (take_ret) begin
            status_q     <= ret_st;
            redir_addr_q <= ret_tgt;
         end else if (do_ld) begin
            status_q     <= st_load_val_i;
         end
      end
   end

   assign status_o     = status_q;
   assign redir_o      = redir_q;
   assign redir_addr_o = redir_addr_q;
   assign flush_o      = flush_q;
   assign vec_err_o    = verr_q;
   assign chkstop_o    = chk_q;

   // R5: a redirect only follows a request
   a_r5_redir_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_q |-> $past(exc_req_i || ret_req_i));
   // R8: checkstop is sticky
   a_r8_chk_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_q |=> chk_q);
   // R8: no redirect while stopped
   a_r8_chk_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_q |-> !redir_q);
   // R6: error and redirect never coincide
   a_r6_err_no_redir: assert property (@(posedge clk_i) disable iff (!rst_ni)
      verr_q |-> !redir_q);
   // R3: machine check handler runs with machine checks off
   a_r3_mchk_me_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (redir_q && $past(take_exc && is_mchk)) |-> !status_q[ME_BIT]);
   // R9: return targets are word aligned
   a_r9_ret_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (redir_q && $past(take_ret)) |-> (redir_addr_q[1:0] == 2'b00));
   // R10: flush only accompanies a redirect
   a_r10_flush_with_redir: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_q |-> redir_q);

endmodule

// File: tb/test_trap_sequencer.sv
`timescale 1ns/1ps
module test_trap_sequencer;

   localparam int XLEN = 32;
   localparam int CW   = 4;
   localparam logic [31:0] BASE = 32'hFFF0_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vec_we = 1'b0;
   logic [CW-1:0]     vec_idx = '0;
   logic [XLEN-1:0]   vec_data = '0;
   logic              st_load = 1'b0;
   logic [XLEN-1:0]   st_val = '0;
   logic              exc_req = 1'b0;
   logic [CW-1:0]     exc_cause = '0;
   logic [XLEN-1:0]   exc_pc = '0;
   logic              ret_req = 1'b0;
   logic [1:0]        ret_kind = '0;
   logic [XLEN-1:0]   status_o, redir_addr_o;
   logic              redir_o, flush_o, vec_err_o, chkstop_o;
   logic [4*XLEN-1:0] save_pc_o, save_st_o;

   always #4 clk = ~clk;

   trap_sequencer i_trap_sequencer (
      .clk_i(clk), .rst_ni(rst_n),
      .vec_we_i(vec_we), .vec_idx_i(vec_idx), .vec_data_i(vec_data),
      .vec_base_i(BASE),
      .st_load_i(st_load), .st_load_val_i(st_val),
      .exc_req_i(exc_req), .exc_cause_i(exc_cause), .exc_pc_i(exc_pc),
      .ret_req_i(ret_req), .ret_kind_i(ret_kind),
      .status_o(status_o), .redir_o(redir_o), .redir_addr_o(redir_addr_o),
      .flush_o(flush_o), .vec_err_o(vec_err_o), .chkstop_o(chkstop_o),
      .save_pc_o(save_pc_o), .save_st_o(save_st_o)
   );

   typedef struct {
      logic        redir;
      logic        err;
      logic        flush;
      logic [31:0] addr;
      logic [31:0] st;
      int          req;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;

   // bench model of architectural state
   logic [31:0] m_st = '0;
   logic [31:0] m_spc [4];
   logic [31:0] m_sst [4];
   logic [31:0] m_vec [16];
   logic        m_chk = 1'b0;

   function automatic int pair_of(input int c);
      if (c == 1) return 3;
      if (c == 2) return 1;
      if (c == 3) return 2;
      return 0;
   endfunction

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   // driver: one request cycle, expectation pushed for the scoreboard
   task automatic drive(input logic e, input int c, input logic [31:0] pc,
                        input logic r, input int k, input logic l,
                        input logic [31:0] lv, input int req);
      exp_t x;
      logic [31:0] sv, spc;
      int p;
      @(negedge clk);
      vec_we = 1'b0;
      exc_req = e; exc_cause = CW'(c); exc_pc = pc;
      ret_req = r; ret_kind = 2'(k);
      st_load = l; st_val = lv;
      x.redir = 1'b0; x.err = 1'b0; x.flush = 1'b0; x.addr = '0; x.req = req;
      if (m_chk) begin
         x.st = m_st;
      end else if (e) begin
         if (c == 1 && !m_st[12]) begin
            m_chk = 1'b1;
         end else if (m_vec[c] == 32'hFFFF_FFFF) begin
            x.err = 1'b1;
         end else begin
            sv  = m_st & ~32'h783F0000;
            spc = (c >= 4 && c <= 7) ? pc - 32'd4 : pc;
            p   = pair_of(c);
            m_spc[p] = spc; m_sst[p] = sv;
            if (c == 1 || c == 3) begin
               m_spc[1] = spc; m_sst[1] = sv;
            end
            x.redir = 1'b1;
            x.addr  = m_vec[c] | BASE;
            x.flush = sv[5] | sv[4];
            m_st    = (c == 1) ? 32'h0 : (m_st & 32'h0000_1000);
         end
         x.st = m_st;
      end else if (r) begin
         x.redir = 1'b1;
         x.addr  = m_spc[k] & ~32'h3;
         m_st    = m_sst[k] & ~((k == 0) ? 32'h783F0000 : 32'h3FFF0000);
         x.st    = m_st;
      end else begin
         if (l) m_st = lv;
         x.st = m_st;
      end
      q.push_back(x);
   endtask

   task automatic idle();
      @(negedge clk);
      vec_we = 1'b0; exc_req = 1'b0; ret_req = 1'b0; st_load = 1'b0;
   endtask

   task automatic wvec(input int idx, input logic [31:0] d);
      @(negedge clk);
      exc_req = 1'b0; ret_req = 1'b0; st_load = 1'b0;
      vec_we = 1'b1; vec_idx = CW'(idx); vec_data = d;
      m_vec[idx] = d;
   endtask

   task automatic check_saves(input int req);
      for (int i = 0; i < 4; i++) begin
         check(req, save_pc_o[i*32 +: 32], m_spc[i], "saved pc");
         check(req, save_st_o[i*32 +: 32], m_sst[i], "saved status");
      end
   endtask

   // monitor: compares outputs after each edge against the queue
   always @(posedge clk) begin
      exp_t x;
      #2;
      if (rst_n) begin
         if (q.size() > 0) begin
            x = q.pop_front();
            checks++;
            if (redir_o !== x.redir || vec_err_o !== x.err || flush_o !== x.flush ||
                status_o !== x.st || (x.redir && redir_addr_o !== x.addr)) begin
               errors++;
               $display("FAIL R%0d redir/err/flush %b%b%b addr %h st %h expected %b%b%b addr %h st %h",
                        x.req, redir_o, vec_err_o, flush_o, redir_addr_o, status_o,
                        x.redir, x.err, x.flush, x.addr, x.st);
            end
         end else if (redir_o !== 1'b0 || flush_o !== 1'b0) begin
            checks++;
            errors++;
            $display("FAIL R5 unrequested pulse redir %b flush %b expected 0 0", redir_o, flush_o);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_spc[i] = '0; m_sst[i] = '0; end
      for (int i = 0; i < 16; i++) m_vec[i] = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state
      check(1, status_o, 32'h0, "reset status");
      check(1, {31'b0, chkstop_o}, 32'h0, "reset checkstop");
      check(1, {30'b0, redir_o, vec_err_o}, 32'h0, "reset pulses");
      check_saves(1);
      // R1 and R6: unwritten vector is undefined
      drive(1, 9, 32'h0000_0800, 0, 0, 0, 0, 6);
      idle();
      for (int c = 0; c < 16; c++) if (c != 14) wvec(c, 32'h100 * c);
      idle();
      // R11: plain status load
      drive(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 11);
      // R2 R3 R5 R10: standard cause, relocation bits set
      drive(1, 9, 32'h0000_1000, 0, 0, 0, 0, 2);
      idle();
      check_saves(2);
      // R4: fault saves pc minus 4, no flush
      drive(1, 5, 32'h0000_2002, 0, 0, 0, 0, 4);
      idle();
      check_saves(4);
      // R7: critical cause into pair 1
      drive(0, 0, 0, 0, 0, 1, 32'h3FFF_1030, 11);
      drive(1, 2, 32'h0000_3000, 0, 0, 0, 0, 7);
      idle();
      check_saves(7);
      // R7: debug into pair 2 with copy into pair 1
      drive(1, 3, 32'h0000_4000, 0, 0, 0, 0, 7);
      idle();
      check_saves(7);
      // R3 R7: machine check with enable set
      drive(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 11);
      drive(1, 1, 32'h0000_5002, 0, 0, 0, 0, 3);
      idle();
      check_saves(7);
      // R9: returns of every kind, back to back
      drive(0, 0, 0, 1, 3, 0, 0, 9);
      drive(0, 0, 0, 1, 0, 0, 0, 9);
      drive(0, 0, 0, 1, 1, 0, 0, 9);
      drive(0, 0, 0, 1, 2, 0, 0, 9);
      idle();
      // R11: exception beats return and load in the same cycle
      drive(0, 0, 0, 0, 0, 1, 32'h0000_1030, 11);
      drive(1, 10, 32'h0000_6000, 1, 2, 1, 32'h1234_5678, 11);
      idle();
      check_saves(11);
      // R6: undefined vector leaves state unchanged
      drive(1, 14, 32'h0000_7000, 0, 0, 0, 0, 6);
      idle();
      check_saves(6);
      // R8: machine check with enable clear stops the block
      drive(0, 0, 0, 0, 0, 1, 32'h0000_0030, 11);
      drive(1, 1, 32'h0000_8000, 0, 0, 0, 0, 8);
      idle();
      check(8, {31'b0, chkstop_o}, 32'h1, "checkstop set");
      drive(1, 9, 32'h0000_9000, 0, 0, 0, 0, 8);
      drive(0, 0, 0, 1, 0, 0, 0, 8);
      drive(0, 0, 0, 0, 0, 1, 32'hAAAA_5555, 8);
      idle();
      idle();
      check(8, {31'b0, chkstop_o}, 32'h1, "checkstop sticky");
      check_saves(8);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule